// File: doc/BRIEF.md
# Auto-Incrementing Transfer Buffer

This block is the staging store that sits between a 32-bit register port and the byte-serial engine of a flash interface controller. It holds 512 bytes. Software moves data through one data register, and a word pointer selects which buffer word that register reaches. Software sets the transfer direction, the auto-advance behaviour and the starting word with a single write to the control register. It then streams words through the data register, and the pointer can step forward after each access.

On the other side, the serial sequencer reads or writes one byte per cycle. Its byte index counts from a programmable base offset, which is usually zero. Bytes are packed little-endian into the 32-bit words. A transfer whose length is not a multiple of four still moves a whole word on the software side, and only the low-order bytes of that word are meaningful. The block does not generate the serial protocol.

If the sequencer and software reach the buffer in the same cycle, the sequencer wins. The software data access then waits with `reg_ready` low.

Top module: `xfer_buf`

## Requirements
- R1: After reset the control register reads 0 (read direction, no auto-advance, pointer 0), the base register reads 0, and neither `reg_rvalid` nor `seq_rvalid` is asserted.
- R2: The buffer holds 512 bytes arranged as 128 words. An auto-advancing pointer steps from word 127 back to word 0, and the sequencer byte address wraps from 511 back to 0.
- R3: Register select 0 is the control register. Bit 31 is the direction (1 means software fills the buffer, 0 means software drains it), bit 30 enables auto-advance, and bits 7:0 hold the word pointer. A write to this register loads the pointer modulo 128, and a read returns the current direction, auto-advance bit and pointer.
- R4: With the direction bit at 1, a write to the data register (select 1) stores the word at the pointer. A read of the data register in this direction returns 0 and leaves the pointer where it was.
- R5: With the direction bit at 0, a read of the data register returns the word at the pointer, with `reg_rvalid`, one cycle after acceptance. A write to the data register in this direction changes neither the buffer nor the pointer.
- R6: With auto-advance set, the pointer increments by one after each data access that takes effect. With auto-advance clear, the pointer stays put, so repeated accesses reach the same word.
- R7: Byte k of word w is byte address 4w+k and occupies bits 8k+7:8k of the word (little-endian). A sequencer byte write changes only that byte.
- R8: Register select 2 holds the sequencer base offset in bits 8:0. The sequencer reaches byte address (base + `seq_idx`) mod 512.
- R9: A sequencer write stores `seq_wdata` at its byte address. A sequencer read returns that byte on `seq_rdata`, with `seq_rvalid`, one cycle later.
- R10: While `seq_req` is high, a data-register access is not accepted (`reg_ready` low) and is held until the sequencer releases the buffer. Control and base accesses are still accepted during that time. Register select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 base, 3 reserved |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Access accepted at this clock edge |
| reg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| reg_rdata | output | 32 | Read data |
| seq_req | input | 1 | Sequencer byte access request |
| seq_we | input | 1 | 1 = sequencer byte write, 0 = byte read |
| seq_idx | input | 9 | Byte index relative to the base offset |
| seq_wdata | input | 8 | Sequencer write byte |
| seq_rvalid | output | 1 | Sequencer read byte valid |
| seq_rdata | output | 8 | Sequencer read byte |

## Verification
The bench uses the default size of 512 bytes. With that size, 128 consecutive words cover the whole buffer, so a short directed sequence started at word 126 crosses the pointer wrap, and a base offset of 510 crosses the byte address wrap. The same size keeps the 7-bit pointer field narrower than the 8-bit control field, which lets the bench show that bit 7 of a pointer write is dropped. The bench also drives a sequencer access and a software data read in the same cycle to confirm that the sequencer takes priority.

// File: rtl/xfer_buf_pkg.sv
package xfer_buf_pkg;
  localparam int REG_W         = 32;
  localparam int CTRL_DIR_BIT  = 31;
  localparam int CTRL_AUTO_BIT = 30;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BASE = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xfer_buf_bank.sv
// One byte lane of the buffer: single port, registered read.
module xfer_buf_bank #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/xfer_buf_arb.sv
// Steers the byte lanes to the sequencer (priority) or to the word-wide software side.
module xfer_buf_arb #(
  parameter int LANES  = 4,
  parameter int AW     = 7,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seq_en,
  input  logic                      seq_we,
  input  logic [LANE_W-1:0]         seq_lane,
  input  logic [AW-1:0]             seq_word,
  input  logic [7:0]                seq_wbyte,
  input  logic                      sw_en,
  input  logic                      sw_we,
  input  logic [AW-1:0]             sw_word,
  input  logic [8*LANES-1:0]        sw_wdata,
  output logic [LANES-1:0]          bank_en,
  output logic [LANES-1:0]          bank_we,
  output logic [LANES-1:0][AW-1:0]  bank_addr,
  output logic [LANES-1:0][7:0]     bank_wdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (seq_en) begin
        bank_en[l]    = (seq_lane == LANE_W'(l));
        bank_we[l]    = seq_we;
        bank_addr[l]  = seq_word;
        bank_wdata[l] = seq_wbyte;
      end else begin
        bank_en[l]    = sw_en;
        bank_we[l]    = sw_we;
        bank_addr[l]  = sw_word;
        bank_wdata[l] = sw_wdata[8*l +: 8];
      end
    end
  end

  // R10: a sequencer cycle owns exactly one lane, software gets none
  a_r10_seq_owns_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    seq_en |-> $countones(bank_en) == 1);
  // R7: a sequencer byte write never touches more than one lane
  a_r7_byte_write_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && seq_we) |-> $onehot0(bank_en & bank_we));
endmodule

// File: rtl/xfer_buf_regs.sv
// Control, data window and base registers; pointer and read-return path.
module xfer_buf_regs
  import xfer_buf_pkg::*;
#(
  parameter int WORD_AW = 7,
  parameter int BYTE_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               seq_busy,
  input  logic [REG_W-1:0]   buf_rword,
  output logic               reg_ready,
  output logic               reg_rvalid,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               sw_en,
  output logic               sw_we,
  output logic [WORD_AW-1:0] sw_word,
  output logic [REG_W-1:0]   sw_wdata,
  output logic [BYTE_AW-1:0] base
);
  localparam logic [WORD_AW-1:0] LAST_WORD = '1;

  reg_sel_e sel;
  logic fire, data_fire, eff;
  logic ctrl_load, base_load, ptr_step;

  logic               dir_q, auto_q, dir_d, auto_d;
  logic [WORD_AW-1:0] ptr_q, ptr_d;
  logic [BYTE_AW-1:0] base_q, base_d;
  logic               rvalid_q, rvalid_d;
  logic               from_buf_q, from_buf_d;
  logic [REG_W-1:0]   rhold_q, rhold_d;
  logic [REG_W-1:0]   ctrl_view;

  assign sel       = reg_sel_e'(reg_sel);
  assign reg_ready = !(seq_busy && sel == SEL_DATA);
  assign fire      = reg_req && reg_ready;
  assign data_fire = fire && sel == SEL_DATA;
  assign eff       = data_fire && (reg_we == dir_q);
  assign ctrl_load = fire && reg_we && sel == SEL_CTRL;
  assign base_load = fire && reg_we && sel == SEL_BASE;
  assign ptr_step  = eff && auto_q;

  assign sw_en    = eff;
  assign sw_we    = reg_we;
  assign sw_word  = ptr_q;
  assign sw_wdata = reg_wdata;
  assign base     = base_q;

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_DIR_BIT]  = dir_q;
    ctrl_view[CTRL_AUTO_BIT] = auto_q;
    ctrl_view[WORD_AW-1:0]   = ptr_q;
  end

  // next state
  always_comb begin
    dir_d      = dir_q;
    auto_d     = auto_q;
    ptr_d      = ptr_q;
    base_d     = base_q;
    rhold_d    = rhold_q;
    rvalid_d   = fire && !reg_we;
    from_buf_d = eff && !reg_we;
    if (ctrl_load) begin
      dir_d  = reg_wdata[CTRL_DIR_BIT];
      auto_d = reg_wdata[CTRL_AUTO_BIT];
      ptr_d  = reg_wdata[WORD_AW-1:0];
    end else if (ptr_step) begin
      ptr_d  = (ptr_q == LAST_WORD) ? '0 : ptr_q + 1'b1;
    end
    if (base_load) base_d = reg_wdata[BYTE_AW-1:0];
    if (fire && !reg_we) begin
      case (sel)
        SEL_CTRL: rhold_d = ctrl_view;
        SEL_BASE: rhold_d = REG_W'(base_q);
        default:  rhold_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= 1'b0;
      auto_q     <= 1'b0;
      ptr_q      <= '0;
      base_q     <= '0;
      rvalid_q   <= 1'b0;
      from_buf_q <= 1'b0;
      rhold_q    <= '0;
    end else begin
      if (ctrl_load) begin
        dir_q  <= dir_d;
        auto_q <= auto_d;
      end
      if (ctrl_load || ptr_step) ptr_q <= ptr_d;
      if (base_load) base_q <= base_d;
      if (fire && !reg_we) rhold_q <= rhold_d;
      rvalid_q   <= rvalid_d;
      from_buf_q <= from_buf_d;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = from_buf_q ? buf_rword : rhold_q;

  // R5: read data only follows an accepted read request
  a_r5_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_req && reg_ready && !reg_we));
  // R6: without auto-advance the pointer does not move on data access
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eff && !auto_q) |=> $stable(ptr_q));
  // R6 and R2: with auto-advance the pointer steps by one, modulo the word count
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eff && auto_q) |=> ptr_q == WORD_AW'($past(ptr_q) + 1'b1));
  // R4 and R5: a data access against the direction leaves the pointer alone
  a_r4_wrong_dir_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !eff) |=> $stable(ptr_q));
endmodule

// File: rtl/xfer_buf.sv
module xfer_buf
  import xfer_buf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int WORD_BYTES = REG_W / 8,
  localparam int LANE_W     = $clog2(WORD_BYTES),
  localparam int BYTE_AW    = $clog2(BUF_BYTES),
  localparam int WORD_AW    = BYTE_AW - LANE_W,
  localparam int WORDS      = BUF_BYTES / WORD_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic               reg_ready,
  output logic               reg_rvalid,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               seq_req,
  input  logic               seq_we,
  input  logic [BYTE_AW-1:0] seq_idx,
  input  logic [7:0]         seq_wdata,
  output logic               seq_rvalid,
  output logic [7:0]         seq_rdata
);
  logic [BYTE_AW-1:0]               base, seq_addr;
  logic                             sw_en, sw_we;
  logic [WORD_AW-1:0]               sw_word;
  logic [REG_W-1:0]                 sw_wdata;
  logic [WORD_BYTES-1:0]            bank_en, bank_we;
  logic [WORD_BYTES-1:0][WORD_AW-1:0] bank_addr;
  logic [WORD_BYTES-1:0][7:0]       bank_wdata, bank_rdata;
  logic [LANE_W-1:0]                lane_q, lane_d;
  logic                             srv_q, srv_d;

  assign seq_addr = base + seq_idx;

  xfer_buf_regs #(.WORD_AW(WORD_AW), .BYTE_AW(BYTE_AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .seq_busy(seq_req), .buf_rword(bank_rdata),
    .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .sw_en(sw_en), .sw_we(sw_we), .sw_word(sw_word), .sw_wdata(sw_wdata),
    .base(base)
  );

  xfer_buf_arb #(.LANES(WORD_BYTES), .AW(WORD_AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .seq_en(seq_req), .seq_we(seq_we),
    .seq_lane(seq_addr[LANE_W-1:0]), .seq_word(seq_addr[BYTE_AW-1:LANE_W]),
    .seq_wbyte(seq_wdata),
    .sw_en(sw_en), .sw_we(sw_we), .sw_word(sw_word), .sw_wdata(sw_wdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_bank
    xfer_buf_bank #(.DEPTH(WORDS)) u_bank (
      .clk(clk), .en(bank_en[l]), .we(bank_we[l]), .addr(bank_addr[l]),
      .wdata(bank_wdata[l]), .rdata(bank_rdata[l])
    );
  end

  // sequencer read return path
  always_comb begin
    srv_d  = seq_req && !seq_we;
    lane_d = srv_d ? seq_addr[LANE_W-1:0] : lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      srv_q  <= srv_d;
      if (srv_d) lane_q <= lane_d;
    end
  end

  assign seq_rvalid = srv_q;
  assign seq_rdata  = bank_rdata[lane_q];

  // R9: a sequencer byte comes back exactly one cycle after its read request
  a_r9_seq_rvalid_origin: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rvalid |-> $past(seq_req && !seq_we));
  // R10: a software data access never reaches the lanes while the sequencer holds them
  a_r10_no_sw_under_seq: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> !sw_en);
endmodule

// File: tb/xfer_buf_tb.sv
module xfer_buf_tb;
  logic        clk, rst_n;
  logic        reg_req, reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_ready, reg_rvalid;
  logic        seq_req, seq_we, seq_rvalid;
  logic [8:0]  seq_idx;
  logic [7:0]  seq_wdata, seq_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rd;
  logic        rv;
  logic [7:0]  sb;
  logic        sv;

  localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_BASE = 2'd2, S_RSVD = 2'd3;

  xfer_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .seq_req(seq_req), .seq_we(seq_we), .seq_idx(seq_idx), .seq_wdata(seq_wdata),
    .seq_rvalid(seq_rvalid), .seq_rdata(seq_rdata)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_sel = sel;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    rv = reg_rvalid; rd = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic seq_write(input logic [8:0] idx, input logic [7:0] b);
    @(negedge clk);
    seq_req = 1'b1; seq_we = 1'b1; seq_idx = idx; seq_wdata = b;
    @(negedge clk);
    seq_req = 1'b0; seq_we = 1'b0;
  endtask

  task automatic seq_read(input logic [8:0] idx);
    @(negedge clk);
    seq_req = 1'b1; seq_we = 1'b0; seq_idx = idx;
    @(negedge clk);
    sv = seq_rvalid; sb = seq_rdata;
    seq_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reg_rvalid idle", {31'b0, reg_rvalid}, 32'd0);
    check("R1 seq_rvalid idle", {31'b0, seq_rvalid}, 32'd0);
    reg_read(S_CTRL);
    check("R1 ctrl rvalid", {31'b0, rv}, 32'd1);
    check("R1 ctrl reset", rd, 32'h0);
    reg_read(S_BASE);
    check("R1 base reset", rd, 32'h0);
    reg_read(S_RSVD);
    check("R10 reserved reads 0", rd, 32'h0);
  endtask

  task automatic t_fill_drain();
    logic [31:0] w [3];
    w[0] = 32'h44332211; w[1] = 32'h88776655; w[2] = 32'h0000AA99;
    reg_write(S_CTRL, 32'hC000_0000);
    for (int i = 0; i < 3; i++) reg_write(S_DATA, w[i]);
    reg_read(S_CTRL);
    check("R6 R3 ptr after 3 writes", rd, 32'hC000_0003);
    reg_write(S_BASE, 32'h0);
    for (int i = 0; i < 10; i++) begin
      seq_read(9'(i));
      check("R9 seq rvalid", {31'b0, sv}, 32'd1);
      check("R7 little-endian byte", {24'b0, sb}, {24'b0, 8'(w[i/4] >> (8*(i%4)))});
    end
  endtask

  task automatic t_seq_fill();
    reg_write(S_CTRL, 32'hC000_0005);
    reg_write(S_DATA, 32'hAABBCCDD);
    reg_write(S_BASE, 32'd16);
    reg_read(S_BASE);
    check("R8 base readback", rd, 32'd16);
    for (int i = 0; i < 6; i++) seq_write(9'(i), 8'(8'h10 + i));
    reg_write(S_CTRL, 32'h4000_0004);
    reg_read(S_DATA);
    check("R5 R8 word4 from seq bytes", rd, 32'h13121110);
    reg_read(S_DATA);
    check("R7 partial word keeps upper bytes", rd, 32'hAABB1514);
    reg_read(S_CTRL);
    check("R6 ptr after 2 reads", rd, 32'h4000_0006);
  endtask

  task automatic t_ignored();
    reg_write(S_CTRL, 32'h4000_0004);
    reg_write(S_DATA, 32'hDEADBEEF);
    reg_read(S_CTRL);
    check("R5 write in read dir keeps ptr", rd, 32'h4000_0004);
    reg_read(S_DATA);
    check("R5 write in read dir keeps data", rd, 32'h13121110);
    reg_write(S_CTRL, 32'hC000_0004);
    reg_read(S_DATA);
    check("R4 read in write dir returns 0", rd, 32'h0);
    reg_read(S_CTRL);
    check("R4 read in write dir keeps ptr", rd, 32'hC000_0004);
  endtask

  task automatic t_no_auto();
    reg_write(S_CTRL, 32'h8000_000A);
    reg_write(S_DATA, 32'h01020304);
    reg_write(S_DATA, 32'h0A0B0C0D);
    reg_read(S_CTRL);
    check("R6 no auto ptr after writes", rd, 32'h8000_000A);
    reg_write(S_CTRL, 32'h0000_000A);
    reg_read(S_DATA);
    check("R6 same word first read", rd, 32'h0A0B0C0D);
    reg_read(S_DATA);
    check("R6 same word second read", rd, 32'h0A0B0C0D);
    reg_read(S_CTRL);
    check("R6 no auto ptr after reads", rd, 32'h0000_000A);
  endtask

  task automatic t_wrap();
    reg_write(S_CTRL, 32'hC000_007E);
    reg_write(S_DATA, 32'hA1A2A3A4);
    reg_write(S_DATA, 32'hB1B2B3B4);
    reg_write(S_DATA, 32'hC1C2C3C4);
    reg_read(S_CTRL);
    check("R2 ptr wraps past 127", rd, 32'hC000_0001);
    reg_write(S_BASE, 32'd510);
    seq_read(9'd0); check("R2 R8 byte 510", {24'b0, sb}, 32'hB2);
    seq_read(9'd1); check("R2 R8 byte 511", {24'b0, sb}, 32'hB1);
    seq_read(9'd2); check("R2 R8 byte wraps to 0", {24'b0, sb}, 32'hC4);
    seq_read(9'd3); check("R2 R8 byte 1", {24'b0, sb}, 32'hC3);
    reg_write(S_CTRL, 32'h0000_0085);
    reg_read(S_CTRL);
    check("R3 ptr loaded modulo 128", rd, 32'h0000_0005);
  endtask

  task automatic t_priority();
    reg_write(S_CTRL, 32'h4000_0004);
    reg_write(S_BASE, 32'd16);
    @(negedge clk);
    seq_req = 1'b1; seq_we = 1'b0; seq_idx = 9'd5;
    reg_req = 1'b1; reg_we = 1'b0; reg_sel = S_DATA;
    #1ns;
    check("R10 data access held", {31'b0, reg_ready}, 32'd0);
    reg_sel = S_CTRL; #1ns;
    check("R10 ctrl access allowed", {31'b0, reg_ready}, 32'd1);
    reg_sel = S_DATA; #1ns;
    @(negedge clk);
    check("R10 seq served first", {31'b0, seq_rvalid}, 32'd1);
    check("R9 seq byte under contention", {24'b0, seq_rdata}, 32'h15);
    check("R10 no sw rvalid yet", {31'b0, reg_rvalid}, 32'd0);
    seq_req = 1'b0; #1ns;
    check("R10 data access released", {31'b0, reg_ready}, 32'd1);
    @(negedge clk);
    check("R10 held read completes", {31'b0, reg_rvalid}, 32'd1);
    check("R10 held read data", reg_rdata, 32'h13121110);
    reg_req = 1'b0;
    reg_read(S_CTRL);
    check("R10 ptr advanced once", rd, 32'h4000_0005);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    seq_req = 1'b0; seq_we = 1'b0; seq_idx = '0; seq_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_seq_fill();
    t_ignored();
    t_no_auto();
    t_wrap();
    t_priority();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule